// File: doc/BRIEF.md
# Stitch Health Degradation Observer

This block watches the pulse train from an optical interrupter that sees a sewing needle move up and down. Each full needle cycle is one stitch. The block times every stitch with a fast sampling counter and compares the duration against a configured limit. A slow stitch is classed as degraded and a fast one as normal.

The class of each stitch feeds a weighted score, the degradation number. The weight added for a stitch depends on both the previous stitch class and the current one. A healthy run of stitches pulls the score back toward zero, but never below it. Runs of degraded stitches drive the score up quickly.

When an update brings the score to a programmable critical level, a sticky alarm goes to the host stitch controller. The alarm stays high until reset or until the host clears it. The score goes on updating while the alarm is high.

Top module: `stitch_health_observer`

## Requirements
- R1: `needle_sense` passes through a two-flop synchronizer, and only its rising edges are used. The first rising edge after reset only starts timing and produces no stitch. Every later rising edge ends a stitch: `stitch_done` is high for exactly one cycle, the cycle that follows the third rising clock edge after the input rises.
- R2: A stitch duration is the number of clock cycles between two consecutive input rising edges. Together with `stitch_done`, `stitch_bad` shows the class: 1 (degraded) when the duration is greater than `dur_limit`, and 0 (normal) when it is less than or equal to `dur_limit`. `stitch_bad` holds that value until the next stitch.
- R3: The duration counter saturates at 2^DUR_W-1. A stalled needle therefore reads as degraded whenever `dur_limit` is below that maximum.
- R4: `stitch_cnt` is 0 after reset. It rises by one in the cycle after each `stitch_done` pulse and saturates at its maximum.
- R5: `degr_num` is 0 after reset. In the cycle after each `stitch_done` it changes by a weight chosen from the pair (previous class, current class):
  - normal→normal: −1
  - degraded→normal: −1
  - normal→degraded: +2
  - degraded→degraded: +3
- R6: A negative weight never takes `degr_num` below 0. At 0, a normal stitch leaves it at 0.
- R7: A positive weight saturates `degr_num` at 2^SCORE_W-1 instead of wrapping.
- R8: The previous-class state resets to normal. The first stitch after reset therefore uses the normal→normal or normal→degraded weight.
- R9: `alarm` is set in the cycle after a stitch update whose new `degr_num` is greater than or equal to `crit_level`. It stays set until reset or until `alarm_clr` is high in a cycle, which clears it in the next cycle. When `alarm_clr` falls in the same cycle as an update that reaches the critical level, the set wins.
- R10: While `alarm` is high, `degr_num` and `stitch_cnt` go on updating per R4 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| needle_sense | input | 1 | Raw optical interrupter signal |
| dur_limit | input | DUR_W | Duration above which a stitch is degraded |
| crit_level | input | SCORE_W | Critical degradation number |
| alarm_clr | input | 1 | Clears the sticky alarm |
| stitch_done | output | 1 | One-cycle pulse per qualified stitch |
| stitch_bad | output | 1 | Class of the last stitch (1 = degraded) |
| degr_num | output | SCORE_W | Degradation number |
| stitch_cnt | output | CNT_W | Qualified stitch count |
| alarm | output | 1 | Sticky alarm to the host controller |

## Verification
Two events can fall in the same cycle: a host clear of the alarm, and a stitch update that brings the score to the critical level. The bench provokes this by raising `alarm_clr` with high probability in exactly the cycle where it expects a `stitch_done`. It also issues random clears elsewhere, so that both orders and the coincident case occur many times. Its cycle model judges each case against R9: set wins on a reaching update, and a clear wins otherwise. It also checks that the score keeps moving either way.

// File: rtl/shp_pkg.sv
package shp_pkg;

  typedef enum logic {
    CLS_NORMAL   = 1'b0,
    CLS_DEGRADED = 1'b1
  } stitch_cls_e;

  typedef enum logic {
    QS_WAIT_FIRST = 1'b0,
    QS_TIMING     = 1'b1
  } qual_state_e;

  // Weight selected by the class transition (previous -> current).
  function automatic int transition_weight(stitch_cls_e prev_c, stitch_cls_e cur_c,
                                           int w_nn, int w_dn, int w_nd, int w_dd);
    int w;
    unique case ({prev_c, cur_c})
      {CLS_NORMAL,   CLS_NORMAL  }: w = w_nn;
      {CLS_DEGRADED, CLS_NORMAL  }: w = w_dn;
      {CLS_NORMAL,   CLS_DEGRADED}: w = w_nd;
      default:                      w = w_dd;
    endcase
    return w;
  endfunction

  // Clamp a signed sum into [0, hi].
  function automatic int clamp_range(int v, int hi);
    if (v < 0)  return 0;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/shp_edge_sync.sv
module shp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chain[i] <= 1'b0;
      else if (i == 0) chain[i] <= din;
      else             chain[i] <= chain[(i == 0) ? 0 : i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;

  // R1: a synchronized rising edge lasts a single cycle
  a_r1_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/shp_stitch_qualifier.sv
module shp_stitch_qualifier
  import shp_pkg::*;
#(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic [DUR_W-1:0] dur_limit,
  output logic             stitch_valid,
  output stitch_cls_e      stitch_cls
);

  localparam logic [DUR_W-1:0] DUR_MAX = {DUR_W{1'b1}};
  localparam logic [DUR_W-1:0] DUR_ONE = DUR_W'(1);

  qual_state_e      state_q, state_d;
  logic [DUR_W-1:0] dur_q;
  logic             stitch_event;
  logic             over_limit;

  // Extended part: trigger evaluation.
  assign stitch_event = rise && (state_q == QS_TIMING);
  assign over_limit   = (dur_q > dur_limit);

  // FSM part.
  always_comb begin
    state_d = state_q;
    if (rise) state_d = QS_TIMING;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= QS_WAIT_FIRST;
    else        state_q <= state_d;
  end

  // Saturating duration counter, restarted by each rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              dur_q <= '0;
    else if (rise)           dur_q <= DUR_ONE;
    else if (dur_q != DUR_MAX) dur_q <= dur_q + DUR_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stitch_valid <= 1'b0;
      stitch_cls   <= CLS_NORMAL;
    end else begin
      stitch_valid <= stitch_event;
      if (stitch_event) stitch_cls <= over_limit ? CLS_DEGRADED : CLS_NORMAL;
    end
  end

  // R3: a saturated counter stays saturated until the next edge
  a_r3_dur_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (dur_q == DUR_MAX && !rise) |=> dur_q == DUR_MAX);
  // R1: stitch pulses are isolated single cycles
  a_r1_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    stitch_valid |=> !stitch_valid);
  // R2: class only moves on a stitch event
  a_r2_class_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !stitch_event |=> $stable(stitch_cls));

endmodule

// File: rtl/shp_score_accum.sv
module shp_score_accum
  import shp_pkg::*;
#(
  parameter int SCORE_W = 8,
  parameter int CNT_W   = 16,
  parameter int W_NN    = -1,
  parameter int W_DN    = -1,
  parameter int W_ND    = 2,
  parameter int W_DD    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stitch_valid,
  input  stitch_cls_e        stitch_cls,
  input  logic [SCORE_W-1:0] crit_level,
  input  logic               alarm_clr,
  output logic [SCORE_W-1:0] score,
  output logic [CNT_W-1:0]   count,
  output logic               alarm
);

  localparam int               SCORE_MAX = (1 << SCORE_W) - 1;
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

  stitch_cls_e        prev_q;
  logic [SCORE_W-1:0] score_next;
  logic               reach;
  int                 weight;

  assign weight     = transition_weight(prev_q, stitch_cls, W_NN, W_DN, W_ND, W_DD);
  assign score_next = SCORE_W'(clamp_range(int'(score) + weight, SCORE_MAX));
  assign reach      = stitch_valid && (score_next >= crit_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      score  <= '0;
      prev_q <= CLS_NORMAL;
      count  <= '0;
    end else if (stitch_valid) begin
      score  <= score_next;
      prev_q <= stitch_cls;
      if (count != CNT_MAX) count <= count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         alarm <= 1'b0;
    else if (reach)     alarm <= 1'b1;
    else if (alarm_clr) alarm <= 1'b0;
  end

  // R6: score at zero stays at zero on a normal stitch
  a_r6_floor_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stitch_valid && score == '0 && stitch_cls == CLS_NORMAL) |=> score == '0);
  // R5: degraded after degraded adds the D->D weight away from the ceiling
  a_r5_dd_adds: assert property (@(posedge clk) disable iff (!rst_n)
    (stitch_valid && prev_q == CLS_DEGRADED && stitch_cls == CLS_DEGRADED
     && int'(score) <= SCORE_MAX - W_DD) |=> score == $past(score) + SCORE_W'(W_DD));
  // R7: ceiling holds under a degraded stitch
  a_r7_ceiling_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stitch_valid && int'(score) == SCORE_MAX && stitch_cls == CLS_DEGRADED)
    |=> int'(score) == SCORE_MAX);
  // R4: count steps by one per stitch below its maximum
  a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (stitch_valid && count != CNT_MAX) |=> count == $past(count) + CNT_W'(1));
  // R9: alarm is sticky without a clear
  a_r9_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !alarm_clr) |=> alarm);
  // R9: a reaching update sets the alarm even against a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    reach |=> alarm);
  // R10: score moves under alarm when the weight is positive and room remains
  a_r10_moves_in_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && stitch_valid && stitch_cls == CLS_DEGRADED && int'(score) < SCORE_MAX)
    |=> score != $past(score));

endmodule

// File: rtl/stitch_health_observer.sv
module stitch_health_observer
  import shp_pkg::*;
#(
  parameter int DUR_W       = 16,
  parameter int SCORE_W     = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int W_NN        = -1,
  parameter int W_DN        = -1,
  parameter int W_ND        = 2,
  parameter int W_DD        = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               needle_sense,
  input  logic [DUR_W-1:0]   dur_limit,
  input  logic [SCORE_W-1:0] crit_level,
  input  logic               alarm_clr,
  output logic               stitch_done,
  output logic               stitch_bad,
  output logic [SCORE_W-1:0] degr_num,
  output logic [CNT_W-1:0]   stitch_cnt,
  output logic               alarm
);

  logic        needle_rise;
  logic        qual_valid;
  stitch_cls_e qual_cls;

  shp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (needle_sense),
    .rise (needle_rise)
  );

  shp_stitch_qualifier #(.DUR_W(DUR_W)) u_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise        (needle_rise),
    .dur_limit   (dur_limit),
    .stitch_valid(qual_valid),
    .stitch_cls  (qual_cls)
  );

  shp_score_accum #(
    .SCORE_W(SCORE_W), .CNT_W(CNT_W),
    .W_NN(W_NN), .W_DN(W_DN), .W_ND(W_ND), .W_DD(W_DD)
  ) u_score (
    .clk         (clk),
    .rst_n       (rst_n),
    .stitch_valid(qual_valid),
    .stitch_cls  (qual_cls),
    .crit_level  (crit_level),
    .alarm_clr   (alarm_clr),
    .score       (degr_num),
    .count       (stitch_cnt),
    .alarm       (alarm)
  );

  assign stitch_done = qual_valid;
  assign stitch_bad  = (qual_cls == CLS_DEGRADED);

  // R8: the first stitch after reset cannot use a degraded-prefixed weight
  a_r8_first_from_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_valid && stitch_cnt == '0 && qual_cls == CLS_NORMAL) |=> degr_num == '0);

endmodule

// File: tb/stitch_health_observer_bench.sv
module stitch_health_observer_bench;

  localparam int DUR_W   = 8;
  localparam int SCORE_W = 6;
  localparam int CNT_W   = 16;
  localparam int THR     = 20;
  localparam int DMAX    = (1 << DUR_W) - 1;
  localparam int SMAX    = (1 << SCORE_W) - 1;
  localparam int NSTITCH = 560;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               needle_sense = 1'b0;
  logic [DUR_W-1:0]   dur_limit = DUR_W'(THR);
  logic [SCORE_W-1:0] crit_level = SCORE_W'(20);
  logic               alarm_clr = 1'b0;
  logic               stitch_done, stitch_bad, alarm;
  logic [SCORE_W-1:0] degr_num;
  logic [CNT_W-1:0]   stitch_cnt;

  stitch_health_observer #(.DUR_W(DUR_W), .SCORE_W(SCORE_W), .CNT_W(CNT_W)) u_stitch_health_observer (
    .clk(clk), .rst_n(rst_n), .needle_sense(needle_sense), .dur_limit(dur_limit),
    .crit_level(crit_level), .alarm_clr(alarm_clr), .stitch_done(stitch_done),
    .stitch_bad(stitch_bad), .degr_num(degr_num), .stitch_cnt(stitch_cnt), .alarm(alarm)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  int vectors = 0;
  int fails = 0;

  // Model state.
  int m_score = 0, m_cnt = 0, m_alarm = 0, m_prev = 0;
  int pend_cyc = -100, pend_deg = 0, pend_sat = 0;
  int armed = 0, last_rise = 0, idx = 0;
  int ph = 0, per = 8, crit_i = 20;

  function automatic int score_after(int s, int prev_bad, int cur_bad);
    int d;
    if (cur_bad != 0) d = (prev_bad != 0) ? 3 : 2;
    else              d = -1;
    s = s + d;
    if (s > SMAX) s = SMAX;
    if (s < 0)    s = 0;
    return s;
  endfunction

  function automatic int pick_period(int n);
    if (n < 40)  return 4 + int'($urandom % (THR - 3));
    if (n < 80)  return THR + 1 + int'($urandom % 40);
    if (n < 150) return 4 + int'($urandom % (THR - 3));
    if (n < 170) return (n % 2 == 0) ? THR : THR + 1;
    if (n >= 184 && n < 187) return 300;
    if (n < 190) return 6;
    if (int'($urandom % 100) < (n - 190) / 4) return THR + 1 + int'($urandom % 30);
    return 4 + int'($urandom % (THR - 3));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    int exp_valid;
    int clr;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // Reset state
    check("R4 reset count", int'(stitch_cnt), 0);
    check("R5 reset score", int'(degr_num), 0);
    check("R9 reset alarm", int'(alarm), 0);
    check("R1 reset done", int'(stitch_done), 0);
    rst_n = 1'b1;
    while (idx < NSTITCH) begin
      @(negedge clk);
      exp_valid = (cyc == pend_cyc) ? 1 : 0;
      // Outputs against the model.
      check("R1 stitch_done timing", int'(stitch_done), exp_valid);
      if (exp_valid != 0)
        check(pend_sat != 0 ? "R3 stalled class" : "R2 class", int'(stitch_bad), pend_deg);
      check("R5 R6 R7 R8 R10 degr_num", int'(degr_num), m_score);
      check("R4 stitch_cnt", int'(stitch_cnt), m_cnt);
      check("R9 alarm", int'(alarm), m_alarm);

      // Drive inputs for this cycle.
      if (idx < 250)      crit_i = 20;
      else if (idx < 400) crit_i = 45;
      else                crit_i = 8;
      crit_level = SCORE_W'(crit_i);
      clr = (exp_valid != 0) ? (($urandom % 3) == 0) : (($urandom % 25) == 0);
      alarm_clr = clr[0];
      if (ph == 0) begin
        needle_sense = 1'b1;
        if (armed != 0) begin
          int dur;
          dur = cyc - last_rise;
          pend_sat = (dur > DMAX) ? 1 : 0;
          if (dur > DMAX) dur = DMAX;
          pend_deg = (dur > THR) ? 1 : 0;
          pend_cyc = cyc + 3;
          idx++;
        end
        armed = 1;
        last_rise = cyc;
        per = pick_period(idx);
      end else if (ph == per / 2) begin
        needle_sense = 1'b0;
      end
      ph = (ph + 1 == per) ? 0 : ph + 1;

      // Predict the state after the next edge.
      if (exp_valid != 0) begin
        int ns;
        ns = score_after(m_score, m_prev, pend_deg);
        m_score = ns;
        if (m_cnt < (1 << CNT_W) - 1) m_cnt++;
        m_prev = pend_deg;
        if (ns >= crit_i)  m_alarm = 1;   // R9 set wins over clear
        else if (clr != 0) m_alarm = 0;
      end else if (clr != 0) begin
        m_alarm = 0;
      end
    end
    repeat (8) begin
      @(negedge clk);
      alarm_clr = 1'b0;
      check("R1 stitch_done tail", int'(stitch_done), (cyc == pend_cyc) ? 1 : 0);
    end
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule